// File: doc/BRIEF.md
# Sign-Extending Universal Shift Register

This block is an eight-position storage register with four clocked behaviours, picked by three active-level controls: keep the value, move right one place with a new bit entering at the top, move right one place while the top bit copies itself (an arithmetic divide by two of a signed value), and take a whole word from the parallel bus. An active-low clear empties the register at once, without waiting for a clock edge, and wins over every clocked behaviour.

The shared parallel bus is split into an input word, an output word and an output-enable flag, so the block has no bidirectional pins. The output word always carries the register contents. The enable flag says when the block would drive the bus: never while a parallel load is selected, and never while the output-enable control is high. The lowest register bit is always present on a separate serial output, so several registers can be chained.

Top module: `sxshift_reg`

## Requirements
- R1: While clr_n is 0 the register is all zeros (data_out = 0, ser_out = 0), from the moment clr_n falls and through every clock edge it spans, whatever the other inputs are.
- R2: With reg_en_n = 1 a rising clock edge leaves data_out unchanged, whatever the other controls and data are.
- R3: With reg_en_n = 0 and shift_nload = 1, a rising edge moves every bit from position i to position i-1 (bit 0 is dropped), for i = 1 to 7.
- R4: In the R3 mode with sext_n = 1, the new bit 7 is ser_a when ser_sel = 0 and ser_b when ser_sel = 1.
- R5: In the R3 mode with sext_n = 0, the new bit 7 equals the old bit 7, and ser_a, ser_b and ser_sel have no effect.
- R6: With reg_en_n = 0 and shift_nload = 0, a rising edge copies data_in into all eight bits (data_in[i] into bit i).
- R7: data_out_en is 1 exactly when shift_nload = 1 and oe_n = 0; it follows those inputs without a clock.
- R8: oe_n has no effect on the register: shifts and loads happen identically with oe_n = 1, and data_out keeps showing the register contents.
- R9: ser_out always equals bit 0 of the register (data_out[0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| reg_en_n | input | 1 | 0 lets the register shift or load, 1 holds |
| shift_nload | input | 1 | 1 selects right shift, 0 selects parallel load |
| sext_n | input | 1 | 0 makes a shift copy the top bit, 1 takes serial entry |
| oe_n | input | 1 | 1 turns the parallel output enable off |
| ser_a | input | 1 | Serial entry source picked when ser_sel is 0 |
| ser_b | input | 1 | Serial entry source picked when ser_sel is 1 |
| ser_sel | input | 1 | Picks the serial entry source |
| data_in | input | 8 | Parallel load word |
| data_out | output | 8 | Register contents |
| data_out_en | output | 1 | 1 when the parallel output would drive the bus |
| ser_out | output | 1 | Bit 0 of the register, always driven |

## Verification
The asynchronous clear and a clocked shift or load can fall in the same cycle: the bench pulls clr_n low in the middle of a cycle in which a random shift or load is set up, holds it across the following rising edge, and releases it mid-cycle. It is judged by reading zero on data_out and ser_out a fraction of a nanosecond after clr_n falls, again after the edge it spanned, and by the register resuming normal updates from zero on the first edge after release. Output-enable changes also share cycles with loads and shifts, and the reference model shows that the register moves regardless.

// File: rtl/sxshift_pkg.sv
`timescale 1ns/1ps
package sxshift_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_LOAD  = 2'd2
  } sx_mode_t;

  // Mode chosen by the active-low enable and the shift/load select.
  function automatic sx_mode_t decode_mode(input logic reg_en_n,
                                           input logic shift_nload);
    if (reg_en_n)
      return MODE_HOLD;
    else if (shift_nload)
      return MODE_SHIFT;
    else
      return MODE_LOAD;
  endfunction

  // Bit that enters the top position on a shift.
  function automatic logic entry_pick(input logic sext_n,
                                      input logic top_bit,
                                      input logic ser_a,
                                      input logic ser_b,
                                      input logic ser_sel);
    if (!sext_n)
      return top_bit;
    else
      return ser_sel ? ser_b : ser_a;
  endfunction

  // Parallel bus drive flag.
  function automatic logic bus_drive(input logic shift_nload,
                                     input logic oe_n);
    return shift_nload & ~oe_n;
  endfunction

endpackage

// File: rtl/sxshift_ctrl.sv
`timescale 1ns/1ps
module sxshift_ctrl
  import sxshift_pkg::*;
(
  input  logic     reg_en_n,
  input  logic     shift_nload,
  input  logic     oe_n,
  output sx_mode_t mode,
  output logic     drive_en
);

  always_comb begin
    mode     = decode_mode(reg_en_n, shift_nload);
    drive_en = bus_drive(shift_nload, oe_n);
  end

endmodule

// File: rtl/sxshift_entry.sv
`timescale 1ns/1ps
module sxshift_entry
  import sxshift_pkg::*;
(
  input  logic sext_n,
  input  logic top_bit,
  input  logic ser_a,
  input  logic ser_b,
  input  logic ser_sel,
  output logic entry_bit
);

  always_comb begin
    entry_bit = entry_pick(sext_n, top_bit, ser_a, ser_b, ser_sel);
  end

endmodule

// File: rtl/sxshift_core.sv
`timescale 1ns/1ps
module sxshift_core
  import sxshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  sx_mode_t         mode,
  input  logic             entry_bit,
  input  logic [WIDTH-1:0] load_word,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] shift_src;
  logic [WIDTH-1:0] nxt;

  // Source of each bit when shifting: its upper neighbour, or the entry bit.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      if (gi == TOP) begin : g_top
        assign shift_src[gi] = entry_bit;
      end else begin : g_mid
        assign shift_src[gi] = q[gi+1];
      end

      always_comb begin
        unique case (mode)
          MODE_SHIFT: nxt[gi] = shift_src[gi];
          MODE_LOAD:  nxt[gi] = load_word[gi];
          default:    nxt[gi] = q[gi];
        endcase
      end

      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
          q[gi] <= 1'b0;
        else
          q[gi] <= nxt[gi];
      end
    end
  endgenerate

endmodule

// File: rtl/sxshift_reg.sv
`timescale 1ns/1ps
module sxshift_reg
  import sxshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             reg_en_n,
  input  logic             shift_nload,
  input  logic             sext_n,
  input  logic             oe_n,
  input  logic             ser_a,
  input  logic             ser_b,
  input  logic             ser_sel,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out,
  output logic             data_out_en,
  output logic             ser_out
);

  sx_mode_t         mode;
  logic             drive_en;
  logic             entry_bit;
  logic [WIDTH-1:0] q;

  // Named events for the checker.
  logic do_hold;
  logic do_shift;
  logic do_load;

  assign do_hold  = (mode == MODE_HOLD);
  assign do_shift = (mode == MODE_SHIFT);
  assign do_load  = (mode == MODE_LOAD);

  sxshift_ctrl i_ctrl (
    .reg_en_n    (reg_en_n),
    .shift_nload (shift_nload),
    .oe_n        (oe_n),
    .mode        (mode),
    .drive_en    (drive_en)
  );

  sxshift_entry i_entry (
    .sext_n    (sext_n),
    .top_bit   (q[WIDTH-1]),
    .ser_a     (ser_a),
    .ser_b     (ser_b),
    .ser_sel   (ser_sel),
    .entry_bit (entry_bit)
  );

  sxshift_core #(.WIDTH(WIDTH)) i_core (
    .clk       (clk),
    .clr_n     (clr_n),
    .mode      (mode),
    .entry_bit (entry_bit),
    .load_word (data_in),
    .q         (q)
  );

  assign data_out    = q;
  assign data_out_en = drive_en;
  assign ser_out     = q[0];

endmodule

// File: rtl/sxshift_chk.sv
`timescale 1ns/1ps
module sxshift_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             reg_en_n,
  input logic             shift_nload,
  input logic             sext_n,
  input logic             oe_n,
  input logic             ser_a,
  input logic             ser_b,
  input logic             ser_sel,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] data_out,
  input logic             data_out_en,
  input logic             ser_out,
  input logic             do_hold,
  input logic             do_shift,
  input logic             do_load
);

  // Clear seen mid-cycle, sampled away from the rising edge.
  always @(negedge clk) begin
    if (!clr_n) begin
      assert_clear_zero_R1: assert (data_out == '0 && ser_out == 1'b0)
        else $error("clear did not empty register");
    end
  end

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!clr_n)
    reg_en_n |=> $stable(data_out));

  assert_shift_move_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (!reg_en_n && shift_nload) |=> data_out[WIDTH-2:0] == $past(data_out[WIDTH-1:1]));

  assert_serial_entry_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (do_shift && sext_n) |=> data_out[WIDTH-1] == $past(ser_sel ? ser_b : ser_a));

  assert_sign_keep_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (do_shift && !sext_n) |=> data_out[WIDTH-1] == $past(data_out[WIDTH-1]));

  assert_load_word_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (!reg_en_n && !shift_nload) |=> data_out == $past(data_in));

  always_comb begin
    if (oe_n || !shift_nload) begin
      assert_bus_off_R7: assert (!data_out_en) else $error("bus driven while off");
    end
    assert_one_mode_R2: assert ($onehot0({do_hold, do_shift, do_load}))
      else $error("more than one mode active");
  end

  assert_oe_no_block_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_n && !reg_en_n && !shift_nload) |=> data_out == $past(data_in));

  always_comb begin
    assert_serial_tap_R9: assert (ser_out == data_out[0]) else $error("serial tap wrong");
  end

endmodule

bind sxshift_reg sxshift_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_sxshift_reg.sv
`timescale 1ns/1ps
module test_sxshift_reg;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       reg_en_n = 1'b1;
  logic       shift_nload = 1'b1;
  logic       sext_n = 1'b1;
  logic       oe_n = 1'b0;
  logic       ser_a = 1'b0;
  logic       ser_b = 1'b0;
  logic       ser_sel = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [7:0] data_out;
  logic       data_out_en;
  logic       ser_out;

  int checks = 0;
  int errors = 0;
  int model = 0;          // reference register value, 0..255
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  sxshift_reg i_sxshift_reg (
    .clk(clk), .clr_n(clr_n), .reg_en_n(reg_en_n), .shift_nload(shift_nload),
    .sext_n(sext_n), .oe_n(oe_n), .ser_a(ser_a), .ser_b(ser_b),
    .ser_sel(ser_sel), .data_in(data_in), .data_out(data_out),
    .data_out_en(data_out_en), .ser_out(ser_out)
  );

  // Behavioural reference: integer arithmetic on the stored value.
  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      model = 0;
    end else if (reg_en_n == 1'b0) begin
      if (shift_nload == 1'b0) begin
        model = int'(data_in);
      end else begin
        int topv;
        if (sext_n == 1'b0) topv = (model >= 128) ? 1 : 0;
        else topv = (ser_sel == 1'b1) ? int'(ser_b) : int'(ser_a);
        model = (model / 2) + topv * 128;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(tag, int'(data_out), model);
    check("R9", int'(ser_out), model % 2);
    check("R7", int'(data_out_en), (shift_nload && !oe_n) ? 1 : 0);
  endtask

  task automatic drive(input logic en_n, input logic sl, input logic sx,
                       input logic oe, input logic a, input logic b,
                       input logic sel, input logic [7:0] d);
    reg_en_n = en_n; shift_nload = sl; sext_n = sx; oe_n = oe;
    ser_a = a; ser_b = b; ser_sel = sel; data_in = d;
    if (en_n) tag = "R2";
    else if (!sl) tag = oe ? "R8" : "R6";
    else if (!sx) tag = "R5";
    else tag = oe ? "R8" : "R4";
  endtask

  // Apply inputs right after a falling edge, then compare at the next one.
  task automatic step(input logic en_n, input logic sl, input logic sx,
                      input logic oe, input logic a, input logic b,
                      input logic sel, input logic [7:0] d);
    drive(en_n, sl, sx, oe, a, b, sel, d);
    @(negedge clk);
    check_all();
  endtask

  // Clear asserted mid-cycle while a random operation is set up.
  task automatic mid_clear();
    drive(1'b0, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'b0,
          1'b1, 1'b1, 1'($urandom_range(1)), 8'hFF);
    #1;
    clr_n = 1'b0;
    #0.5;
    check("R1", int'(data_out), 0);
    check("R1", int'(ser_out), 0);
    @(negedge clk);
    check("R1", int'(data_out), 0);
    #1;
    clr_n = 1'b1;
    @(negedge clk);
    tag = "R3";
    check_all();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1", int'(data_out), 0);
    check("R1", int'(ser_out), 0);
    #1 clr_n = 1'b1;
    @(negedge clk);

    // R6 load, bus off during load (R7)
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    check("R6", int'(data_out), 8'hA5);
    check("R7", int'(data_out_en), 0);
    // R2 hold with busy inputs
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C);
    check("R2", int'(data_out), 8'hA5);
    // R3/R4 shift with ser_a = 1
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R3", int'(data_out), 8'hD2);
    check("R7", int'(data_out_en), 1);
    // R4 ser_b chosen
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    check("R4", int'(data_out), 8'h69);
    check("R9", int'(ser_out), 1);
    // R5 sign extend from 0x80, serial inputs ignored
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R5", int'(data_out), 8'hC0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    check("R5", int'(data_out), 8'hE0);
    // R8 oe_n high: load and shift still update
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
    check("R8", int'(data_out), 8'h5A);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R8", int'(data_out), 8'h2D);
    check("R8", int'(data_out_en), 0);

    mid_clear();

    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(39) == 0) begin
        mid_clear();
      end else begin
        step(1'($urandom_range(3) == 0), 1'($urandom_range(1)),
             1'($urandom_range(1)), 1'($urandom_range(3) == 0),
             1'($urandom_range(1)), 1'($urandom_range(1)),
             1'($urandom_range(1)), 8'($urandom_range(255)));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule